// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Filtering

This block receives asynchronous serial frames on a single line and is meant for a shared multidrop bus. Each frame carries 8 data bits, or 9 when the wide-frame mode is on. In wide mode the top bit tells an address frame (bit set) from a data frame (bit clear). When the address filter is on, data frames are dropped and only address frames are stored. A node therefore sleeps until it is addressed, then turns the filter off to take in the data that follows.

The bit timing comes from a divided system clock. A prescaler makes one sample tick every `baud_div_i + 1` clock cycles. Each bit lasts 16 ticks in fast mode and 64 ticks otherwise. Finished words go into a two-entry queue. The queue is read through a valid/ready port. The head word's data, ninth bit and framing flag are shown while `rd_valid_o` is high, and one word is removed in every cycle where `rd_valid_o` and `rd_ready_i` are both high. The reader may hold `rd_ready_i` low for as long as it likes. Nothing is lost while the queue has room. Once the queue is full, the next accepted word is dropped and the overrun flag is raised.

`rd_valid_o` is the receive-ready flag. The interrupt output is that flag gated by an enable.

Top module: `uart_addr_rx`

## Requirements
- R1: Frames are received only while `port_en_i` is 1, `sync_i` is 0 and `rx_en_i` is 1. In any other setting, a frame on the line leaves `rd_valid_o` at 0.
- R2: In 8-bit mode, a frame is a low start bit, then 8 data bits sent least-significant bit first, then a stop bit. The 8 data bits appear on `rd_data_o`, and `rd_bit9_o` reads 0.
- R3: When `nine_bit_i` is 1, a ninth bit follows the 8 data bits and appears on `rd_bit9_o` with the same word.
- R4: When `nine_bit_i` and `addr_det_i` are both 1, a frame whose ninth bit is 0 is discarded. The queue, `rd_valid_o` and the error flags are left unchanged. A frame whose ninth bit is 1 is stored. `addr_det_i` has no effect in 8-bit mode.
- R5: When `addr_det_i` is 0 in 9-bit mode, frames are stored whatever the value of their ninth bit.
- R6: One bit lasts (`baud_div_i`+1)×16 clock cycles when `fast_i` is 1, and (`baud_div_i`+1)×64 clock cycles when `fast_i` is 0.
- R7: A stop bit sampled low sets `rd_ferr_o` for that word only.
- R8: The queue holds two words and returns them in arrival order. One word is removed per cycle in which `rd_valid_o` and `rd_ready_i` are both 1.
- R9: A word that is accepted while the queue is full sets `overrun_o` and is dropped. While `overrun_o` is 1, no word enters the queue. `overrun_o` is cleared only by driving `rx_en_i` to 0.
- R10: `irq_o` is 1 exactly when `rd_valid_o` is 1 and `irq_en_i` is 1.
- R11: A falling edge counts as a start bit only if the line is still low at the middle of the bit. A shorter low pulse produces no word.
- R12: Each bit value is the majority of three consecutive samples taken around the middle of the bit. A single-sample glitch does not change the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| rx_i | input | 1 | Serial receive line, idles high |
| baud_div_i | input | 8 | Prescaler divisor; one sample tick every value+1 cycles |
| fast_i | input | 1 | 1 selects 16 samples per bit, 0 selects 64 |
| port_en_i | input | 1 | Serial port enable |
| sync_i | input | 1 | Synchronous-mode select; receive runs only when 0 |
| rx_en_i | input | 1 | Continuous receive enable; driving 0 clears overrun and resets the frame logic |
| nine_bit_i | input | 1 | 9-bit frame select |
| addr_det_i | input | 1 | Address filter enable (acts in 9-bit mode only) |
| irq_en_i | input | 1 | Receive interrupt enable |
| rd_valid_o | output | 1 | Queue holds a word (receive-ready flag) |
| rd_ready_i | input | 1 | Reader takes the head word |
| rd_data_o | output | 8 | Head word data byte |
| rd_bit9_o | output | 1 | Head word ninth bit |
| rd_ferr_o | output | 1 | Head word framing error |
| overrun_o | output | 1 | Overrun error flag |
| irq_o | output | 1 | Receive interrupt |

## Verification
The bench checks that a data frame arriving under the address filter leaves the queue untouched. A design that only suppressed the flag, or still raised an error, would show a stale word or a changed count when the next address frame arrives. It fills the queue past its depth and checks that the third word and every later word are dropped until receive is disabled. A design that let words in after an overrun, or cleared the flag on a read, would return the wrong byte sequence. It applies a short false start pulse and a one-sample glitch inside a data bit. A design without the mid-bit start check would report a spurious word, and one without the majority vote would return a corrupted byte. A low stop bit must flag only its own word, and the slow 64-sample mode with a non-zero divisor must decode correctly.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic       ferr;
    logic       bit9;
    logic [7:0] data;
  } rx_word_t;
endpackage

// File: rtl/rx_baud_tick.sv
module rx_baud_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr || !en)     cnt <= '0;
    else if (cnt == div)     cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assign tick = en && !clr && (cnt == div);

  // R6: each tick restarts the prescaler period
  assert_tick_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OS_FAST = 16,
  parameter int OS_SLOW = 64,
  localparam int OSW = $clog2(OS_SLOW)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active,
  input  logic     rx,
  input  logic     nine,
  input  logic     fast,
  input  logic     tick,
  output logic     clr_pre,
  output logic     done,
  output rx_word_t word
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} st_t;
  st_t            st;
  logic [OSW-1:0] os_cnt, os_last, os_mid;
  logic [3:0]     bit_idx, nbits;
  logic [8:0]     shreg;
  logic           v0, v1, vote;

  assign os_last = fast ? OSW'(OS_FAST - 1) : OSW'(OS_SLOW - 1);
  assign os_mid  = fast ? OSW'(OS_FAST / 2) : OSW'(OS_SLOW / 2);
  assign nbits   = nine ? 4'd9 : 4'd8;
  assign vote    = (v0 & v1) | (v0 & rx) | (v1 & rx);
  assign clr_pre = active && (st == S_IDLE) && !rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; os_cnt <= '0; bit_idx <= '0; shreg <= '0;
      v0 <= 1'b1; v1 <= 1'b1; done <= 1'b0; word <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        st <= S_IDLE;
      end else begin
        if (tick && os_cnt == os_mid - 1'b1) v0 <= rx;
        if (tick && os_cnt == os_mid)        v1 <= rx;
        unique case (st)
          S_IDLE: if (!rx) begin st <= S_START; os_cnt <= '0; end
          S_START: if (tick) begin
            if (os_cnt == os_mid && rx) st <= S_IDLE;
            else if (os_cnt == os_last) begin
              st <= S_BITS; os_cnt <= '0; bit_idx <= '0;
            end else os_cnt <= os_cnt + 1'b1;
          end
          S_BITS: if (tick) begin
            if (os_cnt == os_mid + 1'b1) shreg <= {vote, shreg[8:1]};
            if (os_cnt == os_last) begin
              os_cnt <= '0;
              if (bit_idx == nbits - 1'b1) st <= S_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end else os_cnt <= os_cnt + 1'b1;
          end
          S_STOP: if (tick) begin
            if (os_cnt == os_mid + 1'b1) begin
              done      <= 1'b1;
              word.ferr <= ~vote;
              word.bit9 <= nine ? shreg[8] : 1'b0;
              word.data <= nine ? shreg[7:0] : shreg[8:1];
              st        <= S_IDLE;
            end else os_cnt <= os_cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R1: a completed word only follows a cycle in which reception was enabled
  assert_done_when_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(active));
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rx_word_t din,
  input  logic     pop,
  output rx_word_t head,
  output logic     full,
  output logic     not_empty,
  output logic [CW-1:0] count
);
  rx_word_t        mem [DEPTH];
  logic [AW-1:0]   wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     mem[i] <= '0;
      else if (push && wp == AW'(i))  mem[i] <= din;
    end
  end

  assign head      = mem[rp];
  assign full      = (count == CW'(DEPTH));
  assign not_empty = (count != '0);

  // R8: storage never overflows or underflows
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uart_rx_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DEPTH   = 2,
  parameter int OS_FAST = 16,
  parameter int OS_SLOW = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             fast_i,
  input  logic             port_en_i,
  input  logic             sync_i,
  input  logic             rx_en_i,
  input  logic             nine_bit_i,
  input  logic             addr_det_i,
  input  logic             irq_en_i,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_bit9_o,
  output logic             rd_ferr_o,
  output logic             overrun_o,
  output logic             irq_o
);
  logic [1:0] rx_sync;
  logic       active, tick, clr_pre, f_done, reject, accept, push, pop, full, not_empty;
  rx_word_t   f_word, head;
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rx_i};
  end

  assign active = port_en_i && !sync_i && rx_en_i;

  rx_baud_tick #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .en(active), .clr(clr_pre),
    .div(baud_div_i), .tick(tick));

  rx_frame #(.OS_FAST(OS_FAST), .OS_SLOW(OS_SLOW)) u_frame (
    .clk(clk), .rst_n(rst_n), .active(active), .rx(rx_sync[1]),
    .nine(nine_bit_i), .fast(fast_i), .tick(tick), .clr_pre(clr_pre),
    .done(f_done), .word(f_word));

  assign reject = nine_bit_i && addr_det_i && !f_word.bit9;
  assign accept = f_done && !reject;
  assign push   = accept && !overrun_o && !full;
  assign pop    = not_empty && rd_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             overrun_o <= 1'b0;
    else if (!rx_en_i)                      overrun_o <= 1'b0;
    else if (accept && full && !overrun_o)  overrun_o <= 1'b1;
  end

  rx_word_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(f_word), .pop(pop),
    .head(head), .full(full), .not_empty(not_empty), .count(count));

  assign rd_valid_o = not_empty;
  assign rd_data_o  = head.data;
  assign rd_bit9_o  = head.bit9;
  assign rd_ferr_o  = head.ferr;
  assign irq_o      = not_empty && irq_en_i;

  // R9: overrun holds while receive stays enabled
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en_i && $past(rx_en_i) && $past(overrun_o)) |-> overrun_o);
  // R4: a filtered data frame changes neither the queue nor the error flag
  assert_filter_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (f_done && !f_word.bit9 && nine_bit_i && addr_det_i && !rd_ready_i && rx_en_i)
      |=> ($stable(count) && $stable(overrun_o)));
endmodule

// File: tb/tb_uart_addr_rx.sv
module tb_uart_addr_rx;
  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic [7:0] baud_div = 8'd0;
  logic fast = 1'b1, port_en = 1'b1, sync = 1'b0, rx_en = 1'b1;
  logic nine = 1'b0, adet = 1'b0, irq_en = 1'b0, rd_ready = 1'b0;
  logic rd_valid, rd_bit9, rd_ferr, overrun, irq;
  logic [7:0] rd_data;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  uart_addr_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .baud_div_i(baud_div), .fast_i(fast),
    .port_en_i(port_en), .sync_i(sync), .rx_en_i(rx_en), .nine_bit_i(nine),
    .addr_det_i(adet), .irq_en_i(irq_en), .rd_valid_o(rd_valid),
    .rd_ready_i(rd_ready), .rd_data_o(rd_data), .rd_bit9_o(rd_bit9),
    .rd_ferr_o(rd_ferr), .overrun_o(overrun), .irq_o(irq));

  typedef struct packed {
    logic nine; logic adet; logic b9; logic [7:0] data;
    logic stop; logic exp_push; logic exp_ferr;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b1, 1'b0},  // R2
    '{1'b0, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b1},  // R7
    '{1'b1, 1'b0, 1'b1, 8'h5A, 1'b1, 1'b1, 1'b0},  // R3
    '{1'b1, 1'b1, 1'b0, 8'h11, 1'b1, 1'b0, 1'b0},  // R4 rejected
    '{1'b1, 1'b1, 1'b1, 8'h80, 1'b1, 1'b1, 1'b0},  // R4 address
    '{1'b1, 1'b0, 1'b0, 8'hF0, 1'b1, 1'b1, 1'b0},  // R5
    '{1'b0, 1'b1, 1'b0, 8'h01, 1'b1, 1'b1, 1'b0}   // R4 no effect in 8-bit
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int per();
    return (int'(baud_div) + 1) * (fast ? 16 : 64);
  endfunction

  task automatic hold(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  // glitch_bit >= 0 flips one cycle at offset 9 of that data bit (div 0, 16x)
  task automatic send(input logic is9, input logic [7:0] d, input logic b9,
                      input logic stop, input int glitch_bit);
    @(negedge clk);
    hold(1'b0, per());
    for (int i = 0; i < 8; i++) begin
      if (i == glitch_bit) begin
        hold(d[i], 9); hold(~d[i], 1); hold(d[i], per() - 10);
      end else hold(d[i], per());
    end
    if (is9) hold(b9, per());
    hold(stop, per());
    hold(1'b1, per());
  endtask

  task automatic pop1();
    @(negedge clk); rd_ready = 1'b1;
    @(negedge clk); rd_ready = 1'b0;
  endtask

  task automatic expect_word(input string req, input logic [7:0] d,
                             input logic b9, input logic fe);
    chk(req, rd_valid, 1'b1);
    chk(req, rd_data, d);
    chk(req, rd_bit9, b9);
    chk(req, rd_ferr, fe);
    pop1();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R8 reset valid", rd_valid, 0);
    chk("R9 reset overrun", overrun, 0);
    chk("R10 reset irq", irq, 0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      nine = VEC[k].nine; adet = VEC[k].adet;
      send(VEC[k].nine, VEC[k].data, VEC[k].b9, VEC[k].stop, -1);
      chk($sformatf("vec%0d valid", k), rd_valid, VEC[k].exp_push);
      if (VEC[k].exp_push)
        expect_word($sformatf("vec%0d word", k), VEC[k].data, VEC[k].b9, VEC[k].exp_ferr);
      chk($sformatf("vec%0d R9 no overrun", k), overrun, 0);
    end
    nine = 1'b0; adet = 1'b0;

    // R10 interrupt masking
    send(1'b0, 8'h77, 1'b0, 1'b1, -1);
    chk("R10 masked irq", irq, 0);
    irq_en = 1'b1; @(negedge clk);
    chk("R10 enabled irq", irq, 1);
    expect_word("R10 word", 8'h77, 1'b0, 1'b0);
    chk("R10 irq after pop", irq, 0);
    irq_en = 1'b0;

    // R4 filtered frame keeps queue contents and order
    nine = 1'b1; adet = 1'b1;
    send(1'b1, 8'hC1, 1'b1, 1'b1, -1);
    send(1'b1, 8'h99, 1'b0, 1'b0, -1);
    send(1'b1, 8'hC2, 1'b1, 1'b1, -1);
    chk("R4 no overrun after filtered", overrun, 0);
    expect_word("R4 first address", 8'hC1, 1'b1, 1'b0);
    expect_word("R4 second address", 8'hC2, 1'b1, 1'b0);
    chk("R4 queue empty", rd_valid, 0);
    nine = 1'b0; adet = 1'b0;

    // R9 overrun, R8 order
    send(1'b0, 8'h11, 1'b0, 1'b1, -1);
    send(1'b0, 8'h22, 1'b0, 1'b1, -1);
    chk("R9 no overrun at two", overrun, 0);
    send(1'b0, 8'h33, 1'b0, 1'b1, -1);
    chk("R9 overrun set", overrun, 1);
    expect_word("R8 oldest first", 8'h11, 1'b0, 1'b0);
    send(1'b0, 8'h55, 1'b0, 1'b1, -1);
    chk("R9 overrun sticky", overrun, 1);
    expect_word("R8 second", 8'h22, 1'b0, 1'b0);
    chk("R9 no push while overrun", rd_valid, 0);
    @(negedge clk); rx_en = 1'b0; @(negedge clk); rx_en = 1'b1;
    @(negedge clk);
    chk("R9 cleared by rx_en", overrun, 0);

    // R1 receive disabled settings
    sync = 1'b1;
    send(1'b0, 8'h42, 1'b0, 1'b1, -1);
    chk("R1 sync mode ignored", rd_valid, 0);
    sync = 1'b0; port_en = 1'b0;
    send(1'b0, 8'h42, 1'b0, 1'b1, -1);
    chk("R1 port disabled", rd_valid, 0);
    port_en = 1'b1; rx_en = 1'b0;
    send(1'b0, 8'h42, 1'b0, 1'b1, -1);
    chk("R1 receive disabled", rd_valid, 0);
    rx_en = 1'b1;

    // R11 short low pulse
    @(negedge clk); hold(1'b0, 4); hold(1'b1, 4 * per());
    chk("R11 false start", rd_valid, 0);
    send(1'b0, 8'h6E, 1'b0, 1'b1, -1);
    expect_word("R11 after false start", 8'h6E, 1'b0, 1'b0);

    // R12 single-sample glitch
    send(1'b0, 8'h00, 1'b0, 1'b1, 3);
    expect_word("R12 glitch zero", 8'h00, 1'b0, 1'b0);
    send(1'b0, 8'hFF, 1'b0, 1'b1, 5);
    expect_word("R12 glitch ones", 8'hFF, 1'b0, 1'b0);

    // R6 slow mode with divisor
    fast = 1'b0; baud_div = 8'd1;
    send(1'b0, 8'hC3, 1'b0, 1'b1, -1);
    expect_word("R6 slow mode", 8'hC3, 1'b0, 1'b0);
    fast = 1'b1; baud_div = 8'd2;
    send(1'b0, 8'h2D, 1'b0, 1'b1, -1);
    expect_word("R6 fast div 2", 8'h2D, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule